// File: doc/BRIEF.md
# Table-Encoded Clock Ratio Divider

The block divides a fast source clock by a ratio that a 3-bit code selects. A parameter fixes one of four non-linear tables that turn the code into a divisor. Some tables map two codes to the same divisor, and some give odd divisors. Two registered outputs are produced. The first is a square-ish divided clock. The second is a one-cycle strobe that marks the start of each output period, so the block can also drive clock-enable logic.

A gate input sits ahead of the divider. While the gate is low, both outputs stay low and the period counter is held at zero. When the gate rises, the divider starts a fresh period on the next source edge. A new code is taken only when the current output period wraps. A ratio change therefore never cuts a pulse short.

Top module: `ratio_clk_div`

## Requirements
- R1: After reset and before the gate is enabled, `clk_o` and `stb_o` are 0.
- R2: On any source edge where `gate_en` is sampled 0, `clk_o` and `stb_o` become 0. The next edge with the gate high starts a new period.
- R3: With MODE=0, codes 0 to 7 give divisors 2, 2, 3, 4, 5, 6, 7, 8.
- R4: With MODE=1, codes 0 to 7 give divisors 2, 4, 6, 8, 10, 12, 14, 16.
- R5: With MODE=2, codes 0 to 7 give divisors 4, 4, 6, 8, 10, 12, 14, 16.
- R6: With MODE=3, codes 0 to 7 give divisors 4, 8, 12, 16, 20, 24, 28, 32.
- R7: For divisor D, each period lasts D source cycles. `clk_o` is 1 for the first floor(D/2) cycles and 0 for the remaining ceil(D/2) cycles. The first edge with the gate sampled high begins a period with `clk_o` = 1.
- R8: `stb_o` is 1 for exactly the first source cycle of each period and is 0 at all other times.
- R9: `div_code` is sampled only at the edge that begins a period. A change in mid-period leaves the current period at its old length.
- R10: Odd divisors produce a high phase one cycle shorter than the low phase. For example, D=3 gives 1 cycle high and 2 cycles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_en | input | 1 | Gate ahead of the divider; 0 holds the outputs low |
| div_code | input | CODE_W (3) | Ratio selection code |
| clk_o | output | 1 | Divided clock |
| stb_o | output | 1 | One-cycle pulse at the start of each period |

## Verification
Both outputs are registered, so every result is due on the first source edge after the gate or code value that causes it. A gate rise gives `clk_o` = 1 on that edge. A gate drop clears both outputs on that edge. A new code takes effect on the edge where the old period wraps. The bench changes inputs only on falling edges and reads outputs 1 ns after each rising edge. Sample n after enabling therefore maps to counter position n mod D, and each expected value is taken at exactly that index. For the mid-period ratio change, the first eight samples are checked against the old divisor and the following samples against the new one.

// File: rtl/ratio_clk_div.sv
module ratio_clk_div #(
  parameter int MODE   = 0,
  parameter int CODE_W = 3,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_en,
  input  logic [CODE_W-1:0] div_code,
  output logic              clk_o,
  output logic              stb_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  function automatic logic [DIV_W-1:0] ratio_of(input logic [CODE_W-1:0] c);
    logic [DIV_W-1:0] k;
    logic             low2;
    k    = DIV_W'(c) + ONE;
    low2 = (c < CODE_W'(2));
    case (MODE)
      0:       return low2 ? DIV_W'(2) : k;
      1:       return k << 1;
      2:       return low2 ? DIV_W'(4) : (k << 1);
      default: return k << 2;
    endcase
  endfunction

  logic [DIV_W-1:0] cnt, cur_d;
  logic             run;

  wire [DIV_W-1:0] cnt_nx = cnt + ONE;
  wire             wrap   = !run || (cnt == cur_d - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      cur_d <= ratio_of('0);
      run   <= 1'b0;
      clk_o <= 1'b0;
      stb_o <= 1'b0;
    end else if (!gate_en) begin
      cnt   <= '0;
      run   <= 1'b0;
      clk_o <= 1'b0;
      stb_o <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      cur_d <= ratio_of(div_code);
      run   <= 1'b1;
      clk_o <= 1'b1;
      stb_o <= 1'b1;
    end else begin
      cnt   <= cnt_nx;
      clk_o <= (cnt_nx < (cur_d >> 1));
      stb_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ratio_clk_div_chk.sv
module ratio_clk_div_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_en,
  input logic             clk_o,
  input logic             stb_o,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] cur_d
);
  a_r2_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> (!clk_o && !stb_o));

  a_r8_stb_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> ($past(gate_en) && clk_o));

  a_r9_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(cur_d));

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < cur_d);
endmodule

bind ratio_clk_div ratio_clk_div_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .clk_o(clk_o),
  .stb_o(stb_o), .cnt(cnt), .cur_d(cur_d)
);

// File: tb/sim_ratio_clk_div.sv
`timescale 1ns/1ps
module sim_ratio_clk_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_en = 1'b0;
  logic [2:0] div_code = 3'd0;
  logic co [4];
  logic st [4];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ratio_clk_div #(.MODE(0)) u0 (.clk(clk), .rst_n(rst_n), .gate_en(gate_en), .div_code(div_code), .clk_o(co[0]), .stb_o(st[0]));
  ratio_clk_div #(.MODE(1)) u1 (.clk(clk), .rst_n(rst_n), .gate_en(gate_en), .div_code(div_code), .clk_o(co[1]), .stb_o(st[1]));
  ratio_clk_div #(.MODE(2)) u2 (.clk(clk), .rst_n(rst_n), .gate_en(gate_en), .div_code(div_code), .clk_o(co[2]), .stb_o(st[2]));
  ratio_clk_div #(.MODE(3)) u3 (.clk(clk), .rst_n(rst_n), .gate_en(gate_en), .div_code(div_code), .clk_o(co[3]), .stb_o(st[3]));

  function automatic int exp_d(input int m, input int c);
    int t0 [8] = '{2, 2, 3, 4, 5, 6, 7, 8};
    int t1 [8] = '{2, 4, 6, 8, 10, 12, 14, 16};
    int t2 [8] = '{4, 4, 6, 8, 10, 12, 14, 16};
    int t3 [8] = '{4, 8, 12, 16, 20, 24, 28, 32};
    case (m)
      0: return t0[c];
      1: return t1[c];
      2: return t2[c];
      default: return t3[c];
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic samp();
    @(posedge clk);
    #1;
  endtask

  task automatic restart(input logic [2:0] c);
    @(negedge clk) gate_en = 1'b0;
    @(negedge clk) begin div_code = c; gate_en = 1'b1; end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) samp();
    for (int m = 0; m < 4; m++)
      check(!co[m] && !st[m], "R1 reset state", {co[m], st[m]}, 0);
  endtask

  task automatic t_gate_off();
    int bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk) div_code = 3'(i);
      samp();
      for (int m = 0; m < 4; m++) if (co[m] || st[m]) bad++;
    end
    check(bad == 0, "R2 gate held low", bad, 0);
  endtask

  task automatic t_ratios();
    string tag [4] = '{"R3 video table", "R4 storage table", "R5 network table", "R6 general table"};
    for (int c = 0; c < 8; c++) begin
      logic [63:0] hc [4];
      logic [63:0] hs [4];
      restart(3'(c));
      for (int i = 0; i < 64; i++) begin
        samp();
        for (int m = 0; m < 4; m++) begin hc[m][i] = co[m]; hs[m][i] = st[m]; end
      end
      for (int m = 0; m < 4; m++) begin
        int d = exp_d(m, c);
        int bc = 0;
        int bs = 0;
        int hi = 0;
        for (int i = 0; i < 2 * d; i++) begin
          if (hc[m][i] !== ((i % d) < (d / 2))) bc++;
          if (hs[m][i] !== ((i % d) == 0)) bs++;
          if (i < d && hc[m][i]) hi++;
        end
        check(bc == 0, {tag[m], " / R7 waveform"}, bc, 0);
        check(bs == 0, "R8 strobe per period", bs, 0);
        if (d % 2 == 1) check(hi == d / 2, "R10 odd high time", hi, d / 2);
      end
    end
  endtask

  task automatic t_switch();
    int bad = 0;
    logic [13:0] h;
    restart(3'd7);
    for (int i = 0; i < 3; i++) begin samp(); h[i] = co[0]; end
    @(negedge clk) div_code = 3'd2;
    for (int i = 3; i < 14; i++) begin samp(); h[i] = co[0]; end
    for (int i = 0; i < 14; i++) begin
      logic e = (i < 8) ? (i < 4) : (((i - 8) % 3) == 0);
      if (h[i] !== e) bad++;
    end
    check(bad == 0, "R9 ratio change at wrap", bad, 0);
  endtask

  task automatic t_gate_mid();
    restart(3'd7);
    samp(); samp();
    check(co[0] === 1'b1, "R7 high after enable", co[0], 1);
    @(negedge clk) gate_en = 1'b0;
    samp();
    check(!co[0] && !st[0], "R2 gate drop mid period", {co[0], st[0]}, 0);
    @(negedge clk) gate_en = 1'b1;
    samp();
    check(co[0] && st[0], "R2 restart on re-enable", {co[0], st[0]}, 3);
  endtask

  initial begin
    t_reset();
    t_gate_off();
    t_ratios();
    t_switch();
    t_gate_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule